// File: doc/BRIEF.md
# Tag Memory Write Guard with Per-Block Cycle Counters

This block sits between the command layer of a contactless tag and its 18-block by 8-byte memory. For each write request it takes the target block number, the eight new data bytes, the block's present contents and the present contents of the control block (block 17). From these it decides whether the write may go ahead and computes the value that is finally stored. It also keeps a 16-bit write-cycle counter for every block and reports the counter's new value.

Blocks 0 to 15 form four pages of four blocks each. Each page is governed by one byte of the control block, and that byte puts the page in one of three modes: open, bit-clear only (emulated one-time-programmable memory) or per-block write protect. Block 16 holds application bytes and identifier bytes, and three lock bytes guard parts of it. Block 17 holds the protection bytes themselves, and each of them may only move in the locking direction. A second, read-side port reports the lock state, the mode and the cycle count of any block, for use in read replies. The memory array lives outside the block.

Top module: `tagprot_wctl`

## Requirements
- R1: A write to a block number above 17 is denied.
- R2: For a block 4n+k (n = page 0..3, k = 0..3), the guarding byte is byte n of the control block (bits 8n+7:8n). If that byte is neither 0Ah nor of the form Axh, the write is granted and the new data is stored unchanged.
- R3: When the guarding byte equals 0Ah, the write is granted and the stored value is old AND new, so bits can only be cleared.
- R4: When the guarding byte has upper nibble Ah, a write to block 4n+k is denied if bit k of that byte is 1 and granted with unchanged data if bit k is 0.
- R5: A write to block 16 is always granted. Bytes 0–3 keep their old value when control byte 4 equals AAh. Byte 4 keeps its old value when control byte 5 equals AAh. Byte 5 keeps its old value when control byte 6 equals AAh. Bytes 6–7 always take the new value.
- R6: A write to block 17 is denied as a whole if any page byte (control bytes 0–3) makes an illegal move. A byte at 0Ah must stay 0Ah. A byte with upper nibble Ah must keep that upper nibble and may not clear any lower-nibble bit. Otherwise the new value is stored.
- R7: A write to block 17 is denied as a whole if any of control bytes 4–7 currently equals AAh and the new value differs from AAh.
- R8: A granted write increments that block's counter. A denied write leaves every counter unchanged and raises out_err for exactly one cycle.
- R9: The counter holds at FFFFh, and writes to that block are still granted.
- R10: out_valid, out_grant/out_err, out_data and out_count appear on the cycle after wr_valid is sampled. Exactly one of out_grant and out_err is high whenever out_valid is high. Data byte i occupies bits 8i+7:8i.
- R11: One cycle after rd_block is sampled, rd_count shows that block's counter and rd_locked/rd_eprom show its state. For blocks 0–15, rd_locked is the R4 protect bit and rd_eprom means the guarding byte is 0Ah. For block 16, rd_locked means control bytes 4–6 are all AAh. For block 17, rd_locked means control byte 7 is AAh. In all other cases both flags are 0, and rd_count is 0 for blocks above 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears all counters |
| wr_valid | input | 1 | Write request strobe |
| wr_block | input | 5 | Target block number |
| wr_data | input | 64 | New data, byte i at bits 8i+7:8i |
| wr_old | input | 64 | Present contents of the target block |
| ctl_cur | input | 64 | Present contents of block 17 |
| rd_block | input | 5 | Block queried for status |
| out_valid | output | 1 | Result present |
| out_grant | output | 1 | Write allowed; store out_data |
| out_err | output | 1 | Write denied, one-cycle pulse |
| out_block | output | 5 | Block the result belongs to |
| out_data | output | 64 | Merged value to store |
| out_count | output | 16 | Counter value after this request |
| rd_locked | output | 1 | Queried block is write protected |
| rd_eprom | output | 1 | Queried block is in bit-clear-only mode |
| rd_count | output | 16 | Counter of the queried block |

## Verification
Every write result is registered once, so the bench drives a request just after a falling edge and samples out_* at the next falling edge, one rising edge later. The memory and counter models are updated only after that sample. Status queries follow the same one-edge rule and are issued only on cycles with no write, so a counter never changes between the query and the sample. A denial is followed by an idle cycle to show that out_err falls again. The bench also drives one block for 65,537 writes, which checks that the counter holds at FFFFh and that writes are still granted.

// File: rtl/tagprot_pkg.sv
package tagprot_pkg;
  localparam int BYTE_W  = 8;
  localparam int N_BYTES = 8;
  localparam int DATA_W  = BYTE_W * N_BYTES;

  // protection code values
  localparam logic [7:0] CODE_OTP  = 8'h0A;
  localparam logic [3:0] NIB_WP    = 4'hA;
  localparam logic [7:0] CODE_LOCK = 8'hAA;

  typedef logic [DATA_W-1:0] blk_data_t;

  // control block byte positions of the lock bytes (decoded by neighbours)
  localparam int LK_USER = 4;
  localparam int LK_AFI  = 5;
  localparam int LK_DSF  = 6;
  localparam int LK_SELF = 7;

  function automatic logic [7:0] byte_of(input blk_data_t d, input int idx);
    return d[idx*BYTE_W +: BYTE_W];
  endfunction
endpackage

// File: rtl/tp_page_mode.sv
module tp_page_mode
  import tagprot_pkg::*;
#(
  parameter int BLK_W    = 5,
  parameter int PAGES    = 4,
  parameter int PER_PAGE = 4
) (
  input  logic [BLK_W-1:0]        blk,
  input  logic [8*PAGES-1:0]      bp_bytes,
  output logic                    in_user,
  output logic                    otp_mode,
  output logic                    prot_hit
);
  localparam int N_USER = PAGES * PER_PAGE;
  localparam int K_W    = $clog2(PER_PAGE);
  localparam int PG_W   = $clog2(PAGES);

  logic [PG_W-1:0] page;
  logic [K_W-1:0]  k;
  logic [7:0]      bp;

  always_comb begin
    page     = blk[K_W +: PG_W];
    k        = blk[K_W-1:0];
    in_user  = (int'(blk) < N_USER);
    bp       = bp_bytes[8*page +: 8];
    otp_mode = in_user && (bp == CODE_OTP);
    prot_hit = in_user && (bp[7:4] == NIB_WP) && bp[k];
  end
endmodule

// File: rtl/tp_ctl_check.sv
module tp_ctl_check
  import tagprot_pkg::*;
#(
  parameter int N_BP = 4,
  parameter int N_LK = 4
) (
  input  blk_data_t old_ctl,
  input  blk_data_t new_ctl,
  output logic      legal
);
  logic [N_BP+N_LK-1:0] bad;

  generate
    for (genvar i = 0; i < N_BP; i++) begin : g_bp
      logic [7:0] o, v;
      assign o = old_ctl[8*i +: 8];
      assign v = new_ctl[8*i +: 8];
      // otp code frozen; protect nibble frozen, lower bits only set
      assign bad[i] = ((o == CODE_OTP) && (v != CODE_OTP)) ||
                      ((o[7:4] == NIB_WP) &&
                       ((v[7:4] != NIB_WP) || (|(o[3:0] & ~v[3:0]))));
    end
    for (genvar j = 0; j < N_LK; j++) begin : g_lk
      assign bad[N_BP+j] = (old_ctl[8*(N_BP+j) +: 8] == CODE_LOCK) &&
                           (new_ctl[8*(N_BP+j) +: 8] != CODE_LOCK);
    end
  endgenerate

  assign legal = ~|bad;
endmodule

// File: rtl/tp_info_merge.sv
module tp_info_merge
  import tagprot_pkg::*;
(
  input  blk_data_t   new_d,
  input  blk_data_t   old_d,
  input  logic [7:0]  user_lk,
  input  logic [7:0]  afi_lk,
  input  logic [7:0]  dsf_lk,
  output blk_data_t   merged
);
  logic [N_BYTES-1:0] keep;

  always_comb begin
    keep = '0;
    for (int b = 0; b < 4; b++) keep[b] = (user_lk == CODE_LOCK);
    keep[4] = (afi_lk == CODE_LOCK);
    keep[5] = (dsf_lk == CODE_LOCK);
  end

  generate
    for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
      assign merged[8*b +: 8] = keep[b] ? old_d[8*b +: 8] : new_d[8*b +: 8];
    end
  endgenerate
endmodule

// File: rtl/tp_cycle_ctr.sv
module tp_cycle_ctr #(
  parameter int N_BLK = 18,
  parameter int BLK_W = 5,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BLK_W-1:0] wr_idx,
  input  logic             inc_en,
  input  logic [BLK_W-1:0] rd_idx,
  output logic [CNT_W-1:0] cnt_w,
  output logic [CNT_W-1:0] cnt_w_next,
  output logic [CNT_W-1:0] cnt_r
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] mem [N_BLK];

  assign cnt_w      = (int'(wr_idx) < N_BLK) ? mem[wr_idx] : '0;
  assign cnt_r      = (int'(rd_idx) < N_BLK) ? mem[rd_idx] : '0;
  assign cnt_w_next = (cnt_w == CNT_MAX) ? CNT_MAX : cnt_w + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_BLK; i++) mem[i] <= '0;
    end else if (inc_en && (int'(wr_idx) < N_BLK)) begin
      mem[wr_idx] <= cnt_w_next;
    end
  end

  generate
    for (genvar i = 0; i < N_BLK; i++) begin : g_chk
      assert_idle_entry_R8: assert property (@(posedge clk) disable iff (rst)
        !(inc_en && wr_idx == BLK_W'(i)) |=> $stable(mem[i]));
      assert_hold_at_top_R9: assert property (@(posedge clk) disable iff (rst)
        (inc_en && wr_idx == BLK_W'(i) && mem[i] == CNT_MAX) |=> mem[i] == CNT_MAX);
      assert_step_one_R8: assert property (@(posedge clk) disable iff (rst)
        (inc_en && wr_idx == BLK_W'(i) && mem[i] != CNT_MAX) |=>
        mem[i] == $past(mem[i]) + 1'b1);
    end
  endgenerate
endmodule

// File: rtl/tagprot_wctl.sv
module tagprot_wctl
  import tagprot_pkg::*;
#(
  parameter int BLK_W    = 5,
  parameter int CNT_W    = 16,
  parameter int PAGES    = 4,
  parameter int PER_PAGE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_valid,
  input  logic [BLK_W-1:0] wr_block,
  input  logic [63:0]      wr_data,
  input  logic [63:0]      wr_old,
  input  logic [63:0]      ctl_cur,
  input  logic [BLK_W-1:0] rd_block,
  output logic             out_valid,
  output logic             out_grant,
  output logic             out_err,
  output logic [BLK_W-1:0] out_block,
  output logic [63:0]      out_data,
  output logic [CNT_W-1:0] out_count,
  output logic             rd_locked,
  output logic             rd_eprom,
  output logic [CNT_W-1:0] rd_count
);
  localparam int N_USER   = PAGES * PER_PAGE;
  localparam int BLK_INFO = N_USER;
  localparam int BLK_CTL  = N_USER + 1;
  localparam int N_BLK    = N_USER + 2;

  // write side decode
  logic w_user, w_otp, w_prot;
  tp_page_mode #(.BLK_W(BLK_W), .PAGES(PAGES), .PER_PAGE(PER_PAGE)) u_wmode (
    .blk(wr_block), .bp_bytes(ctl_cur[8*PAGES-1:0]),
    .in_user(w_user), .otp_mode(w_otp), .prot_hit(w_prot));

  logic ctl_legal;
  tp_ctl_check #(.N_BP(4), .N_LK(4)) u_ctl (
    .old_ctl(ctl_cur), .new_ctl(wr_data), .legal(ctl_legal));

  blk_data_t info_merged;
  tp_info_merge u_info (
    .new_d(wr_data), .old_d(wr_old),
    .user_lk(byte_of(ctl_cur, LK_USER)), .afi_lk(byte_of(ctl_cur, LK_AFI)),
    .dsf_lk(byte_of(ctl_cur, LK_DSF)), .merged(info_merged));

  logic             ok;
  blk_data_t        store;
  logic [CNT_W-1:0] cnt_w, cnt_w_next, cnt_r;

  always_comb begin
    ok    = 1'b0;
    store = wr_data;
    if (w_user) begin
      ok    = !w_prot;
      store = w_otp ? (wr_old & wr_data) : wr_data;
    end else if (int'(wr_block) == BLK_INFO) begin
      ok    = 1'b1;
      store = info_merged;
    end else if (int'(wr_block) == BLK_CTL) begin
      ok    = ctl_legal;
    end
  end

  tp_cycle_ctr #(.N_BLK(N_BLK), .BLK_W(BLK_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .wr_idx(wr_block), .inc_en(wr_valid && ok),
    .rd_idx(rd_block), .cnt_w(cnt_w), .cnt_w_next(cnt_w_next), .cnt_r(cnt_r));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_grant <= 1'b0;
      out_err   <= 1'b0;
      out_block <= '0;
      out_data  <= '0;
      out_count <= '0;
    end else begin
      out_valid <= wr_valid;
      out_grant <= wr_valid && ok;
      out_err   <= wr_valid && !ok;
      if (wr_valid) begin
        out_block <= wr_block;
        out_data  <= store;
        out_count <= ok ? cnt_w_next : cnt_w;
      end
    end
  end

  // read side status
  logic r_user, r_otp, r_prot;
  tp_page_mode #(.BLK_W(BLK_W), .PAGES(PAGES), .PER_PAGE(PER_PAGE)) u_rmode (
    .blk(rd_block), .bp_bytes(ctl_cur[8*PAGES-1:0]),
    .in_user(r_user), .otp_mode(r_otp), .prot_hit(r_prot));

  logic r_lock_c;
  always_comb begin
    if (r_user)
      r_lock_c = r_prot;
    else if (int'(rd_block) == BLK_INFO)
      r_lock_c = (byte_of(ctl_cur, LK_USER) == CODE_LOCK) &&
                 (byte_of(ctl_cur, LK_AFI) == CODE_LOCK) &&
                 (byte_of(ctl_cur, LK_DSF) == CODE_LOCK);
    else if (int'(rd_block) == BLK_CTL)
      r_lock_c = (byte_of(ctl_cur, LK_SELF) == CODE_LOCK);
    else
      r_lock_c = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_locked <= 1'b0;
      rd_eprom  <= 1'b0;
      rd_count  <= '0;
    end else begin
      rd_locked <= r_lock_c;
      rd_eprom  <= r_otp;
      rd_count  <= cnt_r;
    end
  end

  // checks on the result stage
  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $onehot({out_grant, out_err}));
  assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !(out_grant || out_err));
  assert_oob_deny_R1: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && int'(wr_block) >= N_BLK) |=> out_err);
  assert_otp_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && int'(wr_block) < N_USER &&
     ctl_cur[8*wr_block[3:2] +: 8] == CODE_OTP) |=>
    (out_grant && ((out_data & ~$past(wr_old)) == '0)));
  assert_lock_fixed_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && int'(wr_block) == BLK_CTL && ctl_cur[63:56] == CODE_LOCK &&
     wr_data[63:56] != CODE_LOCK) |=> out_err);
  assert_err_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    out_err |-> $past(wr_valid));
  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    out_grant |-> out_count != '0);
endmodule

// File: tb/test_tagprot_wctl.sv
module test_tagprot_wctl;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_valid;
  logic [4:0]  wr_block;
  logic [63:0] wr_data, wr_old, ctl_cur;
  logic [4:0]  rd_block;
  logic        out_valid, out_grant, out_err, rd_locked, rd_eprom;
  logic [4:0]  out_block;
  logic [63:0] out_data;
  logic [15:0] out_count, rd_count;

  always #4 clk = ~clk; // 125 MHz

  tagprot_wctl i_tagprot_wctl (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_block(wr_block),
    .wr_data(wr_data), .wr_old(wr_old), .ctl_cur(ctl_cur), .rd_block(rd_block),
    .out_valid(out_valid), .out_grant(out_grant), .out_err(out_err),
    .out_block(out_block), .out_data(out_data), .out_count(out_count),
    .rd_locked(rd_locked), .rd_eprom(rd_eprom), .rd_count(rd_count));

  int total = 0, bad = 0;
  bit done = 0;
  logic [63:0] mem [18];
  int unsigned cnt [18];

  task automatic chk(input bit c, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!c) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic void model(input int blk, input logic [63:0] nd,
      input logic [63:0] od, input logic [63:0] ctl,
      output bit ok, output logic [63:0] st);
    logic [7:0] bp, o, v;
    ok = 0; st = nd;
    if (blk < 16) begin
      bp = ctl[8*(blk/4) +: 8];
      if (bp == 8'h0A) begin ok = 1; st = od & nd; end
      else if (bp[7:4] == 4'hA && bp[blk%4]) ok = 0;
      else ok = 1;
    end else if (blk == 16) begin
      ok = 1;
      for (int b = 0; b < 8; b++) begin
        bit keep = (b < 4 && ctl[39:32] == 8'hAA) || (b == 4 && ctl[47:40] == 8'hAA) ||
                   (b == 5 && ctl[55:48] == 8'hAA);
        if (keep) st[8*b +: 8] = od[8*b +: 8];
      end
    end else if (blk == 17) begin
      ok = 1;
      for (int b = 0; b < 8; b++) begin
        o = ctl[8*b +: 8]; v = nd[8*b +: 8];
        if (b < 4) begin
          if (o == 8'h0A && v != 8'h0A) ok = 0;
          if (o[7:4] == 4'hA && (v[7:4] != 4'hA || (o[3:0] & ~v[3:0]) != 0)) ok = 0;
        end else if (o == 8'hAA && v != 8'hAA) ok = 0;
      end
    end
  endfunction

  task automatic do_write(input int blk, input logic [63:0] nd, input string req);
    bit ok; logic [63:0] st, od; int unsigned ec;
    od = (blk < 18) ? mem[blk] : 64'h0;
    model(blk, nd, od, mem[17], ok, st);
    wr_valid = 1; wr_block = 5'(blk); wr_data = nd; wr_old = od; ctl_cur = mem[17];
    @(posedge clk); @(negedge clk);
    wr_valid = 0;
    ec = (blk < 18) ? cnt[blk] : 0;
    if (ok && ec < 65535) ec++;
    chk(out_valid === 1'b1, req, "valid", 64'(out_valid), 1);
    chk(out_grant === ok && out_err === !ok, req, "grant", 64'(out_grant), 64'(ok));
    chk(out_count === 16'(ec), req, "count", 64'(out_count), 64'(ec));
    if (ok) begin
      chk(out_data === st, req, "data", out_data, st);
      mem[blk] = st; cnt[blk] = ec;
    end
  endtask

  task automatic idle_err_check(input string req);
    @(posedge clk); @(negedge clk);
    chk(out_err === 1'b0 && out_valid === 1'b0, req, "err pulse", 64'(out_err), 0);
  endtask

  task automatic do_query(input int blk, input string req);
    logic [7:0] bp; bit el = 0, ee = 0;
    if (blk < 16) begin
      bp = mem[17][8*(blk/4) +: 8];
      el = (bp[7:4] == 4'hA) && bp[blk%4];
      ee = (bp == 8'h0A);
    end else if (blk == 16)
      el = mem[17][39:32] == 8'hAA && mem[17][47:40] == 8'hAA && mem[17][55:48] == 8'hAA;
    else if (blk == 17)
      el = mem[17][63:56] == 8'hAA;
    rd_block = 5'(blk); ctl_cur = mem[17];
    @(posedge clk); @(negedge clk);
    chk(rd_locked === el, req, "rd_locked", 64'(rd_locked), 64'(el));
    chk(rd_eprom === ee, req, "rd_eprom", 64'(rd_eprom), 64'(ee));
    chk(rd_count === 16'((blk < 18) ? cnt[blk] : 0), req, "rd_count", 64'(rd_count),
        64'((blk < 18) ? cnt[blk] : 0));
  endtask

  task automatic do_reset();
    rst = 1; wr_valid = 0; wr_block = 0; wr_data = 0; wr_old = 0; ctl_cur = 0; rd_block = 0;
    for (int i = 0; i < 18; i++) begin mem[i] = 0; cnt[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
  endtask

  function automatic logic [63:0] set_byte(input logic [63:0] d, input int b,
                                           input logic [7:0] v);
    logic [63:0] r = d; r[8*b +: 8] = v; return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] c;
    void'($urandom(32'h5EED_0042));
    do_reset();
    chk(out_valid === 0 && out_err === 0 && out_count === 0, "R10", "reset out", 64'(out_valid), 0);
    do_query(3, "R11");

    do_write(5, 64'h0123_4567_89AB_CDEF, "R2");
    do_write(18, 64'h1, "R1"); idle_err_check("R8");
    do_write(31, 64'h2, "R1");

    // saturation of block 2 (page 0 open)
    for (int i = 0; i < 65537; i++) do_write(2, 64'(i), "R9");
    chk(cnt[2] == 65535, "R9", "model sat", 64'(cnt[2]), 65535);
    do_query(2, "R11");

    // page 1 per-block protect, block 5 locked
    do_write(17, set_byte(mem[17], 1, 8'hA2), "R6");
    do_write(5, 64'hFFFF, "R4"); idle_err_check("R8");
    do_query(5, "R11");
    do_write(4, 64'hBEEF, "R4");
    do_write(17, set_byte(mem[17], 1, 8'hA0), "R6");
    do_write(17, set_byte(mem[17], 1, 8'h52), "R6");
    do_write(17, set_byte(mem[17], 1, 8'hA6), "R6");
    do_write(6, 64'h77, "R4");

    // page 0 bit-clear mode
    do_write(1, 64'hF0F0_F0F0_FFFF_0000, "R2");
    do_write(17, set_byte(mem[17], 0, 8'h0A), "R6");
    do_write(1, 64'h0FF0_FFFF_00FF_FFFF, "R3");
    do_query(1, "R11");
    do_write(17, set_byte(mem[17], 0, 8'h00), "R6");

    // block 16 guards
    do_write(16, 64'h1111_2222_3333_4444, "R5");
    c = set_byte(mem[17], 4, 8'hAA); c = set_byte(c, 5, 8'hAA);
    do_write(17, c, "R7");
    do_write(16, 64'h9999_8888_7777_6666, "R5");
    do_write(17, set_byte(mem[17], 4, 8'h00), "R7");
    do_write(17, set_byte(set_byte(mem[17], 7, 8'hAA), 6, 8'hAA), "R7");
    do_query(16, "R11"); do_query(17, "R11");
    do_write(17, set_byte(mem[17], 7, 8'h12), "R7");
    do_write(17, set_byte(mem[17], 2, 8'h3C), "R6");

    // constrained random phase
    do_reset();
    for (int n = 0; n < 3000; n++) begin
      int unsigned sel = $urandom_range(0, 9);
      if (sel < 3) begin
        logic [7:0] v;
        int unsigned pick = $urandom_range(0, 4);
        v = (pick == 0) ? 8'h00 : (pick == 1) ? 8'h0A : (pick == 2) ? 8'hAA :
            (pick == 3) ? {4'hA, 4'($urandom)} : 8'($urandom);
        do_write(17, set_byte(mem[17], $urandom_range(0, 7), v), "R6");
      end else if (sel == 9) begin
        do_query($urandom_range(0, 19), "R11");
      end else begin
        do_write($urandom_range(0, 19), {$urandom, $urandom}, "R2");
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule